// File: doc/BRIEF.md
# Biphase-Mark Audio Line Transmitter with Output Routing

The block turns stereo PCM samples into a two-channel biphase-mark audio line stream in the consumer/professional subframe format. Samples are written into a left and a right holding register through a write strobe with a channel flag. The encoder reads the holding register of the matching channel at the start of every subframe. Each subframe carries the audio word, a validity flag, a user bit, one channel-status bit and even parity. The channel-status bit is taken from a 40-bit configuration word for the first 40 frames of each 192-frame block and is 0 after that.

In consumer mode (status bit 0 cleared) the channel-number field, status bits 20 to 23, does not come from the configuration word. A control input either fills it automatically per channel or clears it. The user bit is either held at zero or looped back from a recovered-user-bit input. The loop path is taken only while a lock input and a master-mode input are both high.

A final routing stage drives the line pin. It drives either the local encoder stream or one of eight raw receiver inputs passed straight through. The pin is registered, so it lags its source by one clock. The line runs at one half-cell per `HALF_DIV` clocks.

Top module: `spdif_tx_mux`

## Requirements
- R1: While `rst_n` is low, `tx_out` is 0. The first subframe the encoder sends after reset is a left subframe with the block-start preamble, and its audio and validity fields are 0.
- R2: Preamble half-cell patterns are given relative to the line level L before the subframe, where 1 means ~L and 0 means L, first half-cell first. Block start is 11101000, left is 11100010 and right is 11100100. Block start is used on the left subframe of frame 0 of every 192 frames, left on every other left subframe, and right on every right subframe.
- R3: In slots 4 to 31 the line changes level at the start of every cell. It changes again at mid-cell exactly when the slot's bit is 1.
- R4: Slots 4 to 27 hold the written sample LSB first, with samples narrower than 24 bits left-aligned and zero-filled below. Slot 28 is the sample's validity flag and slot 31 makes slots 4 to 31 even parity.
- R5: Slot 30 of the subframes in frame f, for f below 40, is `cs_bits[f]`. Frames 20 to 23 in consumer mode are the exception and follow R6 and R7. For f of 40 or more, slot 30 is 0.
- R6: With `cs_bits[0]`=0 and `cs_auto_chan`=1, status bits 20,21,22,23 are 1,0,0,0 on the left subframe and 0,1,0,0 on the right one.
- R7: With `cs_bits[0]`=0 and `cs_auto_chan`=0, status bits 20 to 23 are 0 on both channels, whatever `cs_bits[23:20]` holds.
- R8: With `cs_bits[0]`=1, status bits 20 to 23 are `cs_bits[23:20]` on both channels.
- R9: With `ubit_loop`=0, slot 29 (user bit) is 0.
- R10: With `ubit_loop`=1, slot 29 equals `ubit_rec` when `pll_lock` and `master_mode` are both 1. Otherwise it is 0.
- R11: With `enc_sel`=0, `tx_out` equals `rx_in[rx_sel]` from the previous clock.
- R12: With `enc_sel`=1, `tx_out` is the encoder line from the previous clock, and that line decodes to valid subframes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_wr | input | 1 | Sample write strobe |
| pcm_rsel | input | 1 | Write target: 0 left, 1 right |
| pcm_data | input | AUD_W | Sample value |
| pcm_vbit | input | 1 | Validity flag stored with the sample |
| cs_bits | input | 40 | Channel-status bits 0 to 39 |
| cs_auto_chan | input | 1 | Consumer channel-number auto fill |
| ubit_loop | input | 1 | User bit from recovered input when 1 |
| pll_lock | input | 1 | Receiver lock indication |
| master_mode | input | 1 | Block is clock master |
| ubit_rec | input | 1 | Recovered user bit |
| enc_sel | input | 1 | 1 selects encoder stream, 0 pass-through |
| rx_sel | input | SEL_W | Pass-through input select |
| rx_in | input | NRX | Raw receiver line inputs |
| tx_out | output | 1 | Line output |

## Verification
Two kinds of internal fault show quickly at the pin. A half-cell index or line register that slips breaks cell-edge regularity or a preamble shape within one subframe, which is 64 half-cells. A stale latched word shows as a parity or field error in that same subframe. A frame counter that skips or wraps wrongly shows only at the next block-start preamble, up to 192 frames later. The bench therefore decodes whole blocks from one block start to the next. Status-bit selection faults land on fixed frames (20 to 23, and the 40 boundary), so each mode is checked over a full block.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
    localparam int SLOTS   = 32;
    localparam int HALVES  = 2 * SLOTS;
    localparam int FRAMES  = 192;
    localparam int FRM_W   = $clog2(FRAMES);
    localparam int CS_W    = 40;
    localparam int PCM_W   = 24;
    localparam int CHAN_LO = 20;

    // half-cell patterns, MSB first, 1 = opposite of the level before
    localparam logic [7:0] PRE_BLK   = 8'b1110_1000;
    localparam logic [7:0] PRE_LEFT  = 8'b1110_0010;
    localparam logic [7:0] PRE_RIGHT = 8'b1110_0100;

    typedef logic [SLOTS-1:0] sf_word_t;
endpackage

// File: rtl/spdif_cs_bit.sv
module spdif_cs_bit
    import spdif_tx_pkg::*;
(
    input  logic [FRM_W-1:0] frame,
    input  logic             side,
    input  logic [CS_W-1:0]  cs_reg,
    input  logic             auto_chan,
    output logic             cbit
);
    logic [CS_W-1:0] shifted;
    logic            in_chan;

    always_comb begin
        shifted = cs_reg >> frame;
        in_chan = (frame >= FRM_W'(CHAN_LO)) && (frame <= FRM_W'(CHAN_LO + 3));
        cbit    = shifted[0];
        if (!cs_reg[0] && in_chan) begin
            if (auto_chan)
                cbit = side ? (frame == FRM_W'(CHAN_LO + 1)) : (frame == FRM_W'(CHAN_LO));
            else
                cbit = 1'b0;
        end
    end
endmodule

// File: rtl/spdif_sf_build.sv
module spdif_sf_build
    import spdif_tx_pkg::*;
#(
    parameter int AUD_W = 24
) (
    input  logic [AUD_W-1:0] audio,
    input  logic             vbit,
    input  logic             ubit,
    input  logic             cbit,
    output sf_word_t         word
);
    logic [PCM_W-1:0] aligned;

    always_comb begin
        aligned      = PCM_W'(audio) << (PCM_W - AUD_W);
        word         = '0;
        word[27:4]   = aligned;
        word[28]     = vbit;
        word[29]     = ubit;
        word[30]     = cbit;
        word[31]     = ^{cbit, ubit, vbit, aligned};
    end
endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
    import spdif_tx_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sf_word_t         word_in,
    output logic             line,
    output logic [5:0]       half,
    output logic [FRM_W-1:0] frame,
    output logic             side,
    output logic             tick
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [5:0]       half;
        logic             side;
        logic [FRM_W-1:0] frame;
        logic             line;
        logic             pre;
        sf_word_t         word;
    } enc_st_t;

    enc_st_t st_d, st_q;
    logic    tick_c;
    logic [7:0] pat;

    always_comb begin
        st_d   = st_q;
        tick_c = (st_q.div == DIV_W'(HALF_DIV - 1));
        pat    = st_q.side ? PRE_RIGHT : ((st_q.frame == '0) ? PRE_BLK : PRE_LEFT);
        if (tick_c) begin
            st_d.div  = '0;
            st_d.half = st_q.half + 6'd1;
            if (st_q.half == 6'd0) begin
                st_d.word = word_in;
                st_d.pre  = st_q.line;
                st_d.line = ~st_q.line;
            end else if (st_q.half < 6'd8) begin
                st_d.line = pat[3'd7 - st_q.half[2:0]] ? ~st_q.pre : st_q.pre;
            end else if (!st_q.half[0]) begin
                st_d.line = ~st_q.line;
            end else begin
                st_d.line = st_q.line ^ st_q.word[st_q.half[5:1]];
            end
            if (st_q.half == 6'd63) begin
                st_d.side = ~st_q.side;
                if (st_q.side)
                    st_d.frame = (st_q.frame == FRM_W'(FRAMES - 1)) ? '0 : st_q.frame + 1'b1;
            end
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line  = st_q.line;
    assign half  = st_q.half;
    assign frame = st_q.frame;
    assign side  = st_q.side;
    assign tick  = tick_c;
endmodule

// File: rtl/spdif_tx_mux.sv
module spdif_tx_mux
    import spdif_tx_pkg::*;
#(
    parameter int AUD_W    = 24,
    parameter int HALF_DIV = 4,
    parameter int NRX      = 8,
    parameter int SEL_W    = $clog2(NRX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pcm_wr,
    input  logic             pcm_rsel,
    input  logic [AUD_W-1:0] pcm_data,
    input  logic             pcm_vbit,
    input  logic [CS_W-1:0]  cs_bits,
    input  logic             cs_auto_chan,
    input  logic             ubit_loop,
    input  logic             pll_lock,
    input  logic             master_mode,
    input  logic             ubit_rec,
    input  logic             enc_sel,
    input  logic [SEL_W-1:0] rx_sel,
    input  logic [NRX-1:0]   rx_in,
    output logic             tx_out
);
    typedef struct packed {
        logic [AUD_W-1:0] aud_l;
        logic [AUD_W-1:0] aud_r;
        logic             v_l;
        logic             v_r;
        logic             out;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             enc_line, enc_side, enc_tick, u_bit, c_bit;
    logic [5:0]       enc_half;
    logic [FRM_W-1:0] enc_frame;
    sf_word_t         sf_word;

    assign u_bit = ubit_loop && pll_lock && master_mode && ubit_rec;

    spdif_cs_bit i_cs (
        .frame(enc_frame), .side(enc_side), .cs_reg(cs_bits),
        .auto_chan(cs_auto_chan), .cbit(c_bit)
    );

    spdif_sf_build #(.AUD_W(AUD_W)) i_build (
        .audio(enc_side ? st_q.aud_r : st_q.aud_l),
        .vbit (enc_side ? st_q.v_r : st_q.v_l),
        .ubit (u_bit), .cbit(c_bit), .word(sf_word)
    );

    spdif_bmc_enc #(.HALF_DIV(HALF_DIV)) i_enc (
        .clk(clk), .rst_n(rst_n), .word_in(sf_word), .line(enc_line),
        .half(enc_half), .frame(enc_frame), .side(enc_side), .tick(enc_tick)
    );

    always_comb begin
        st_d = st_q;
        if (pcm_wr) begin
            if (pcm_rsel) begin
                st_d.aud_r = pcm_data;
                st_d.v_r   = pcm_vbit;
            end else begin
                st_d.aud_l = pcm_data;
                st_d.v_l   = pcm_vbit;
            end
        end
        st_d.out = enc_sel ? enc_line : rx_in[rx_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_out = st_q.out;
endmodule

// File: rtl/spdif_tx_mux_chk.sv
module spdif_tx_mux_chk
    import spdif_tx_pkg::*;
#(
    parameter int NRX   = 8,
    parameter int SEL_W = $clog2(NRX)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enc_sel,
    input logic [SEL_W-1:0] rx_sel,
    input logic [NRX-1:0]   rx_in,
    input logic             tx_out,
    input logic             enc_line,
    input logic             enc_tick,
    input logic [5:0]       enc_half,
    input logic [FRM_W-1:0] enc_frame,
    input logic             enc_side,
    input logic             ubit_loop,
    input logic             pll_lock,
    input logic             master_mode,
    input logic             u_bit
);
    p_pass_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_sel |=> tx_out == $past(rx_in[rx_sel]));

    p_encoder_route_r12: assert property (@(posedge clk) disable iff (!rst_n)
        enc_sel |=> tx_out == $past(enc_line));

    p_cell_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_tick && enc_half >= 6'd8 && !enc_half[0]) |=> enc_line != $past(enc_line));

    p_preamble_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_tick && enc_half == 6'd0) |=> enc_line != $past(enc_line));

    p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_tick |=> $stable(enc_line));

    p_frame_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_frame < FRM_W'(FRAMES));

    p_frame_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_tick && enc_half == 6'd63 && enc_side) |=>
        enc_frame == (($past(enc_frame) == FRM_W'(FRAMES - 1)) ? '0 : $past(enc_frame) + 1'b1));

    p_user_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ubit_loop |-> !u_bit);

    p_user_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_lock && master_mode) |-> !u_bit);
endmodule

bind spdif_tx_mux spdif_tx_mux_chk #(.NRX(NRX), .SEL_W(SEL_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .enc_sel(enc_sel), .rx_sel(rx_sel), .rx_in(rx_in),
    .tx_out(tx_out), .enc_line(enc_line), .enc_tick(enc_tick), .enc_half(enc_half),
    .enc_frame(enc_frame), .enc_side(enc_side), .ubit_loop(ubit_loop),
    .pll_lock(pll_lock), .master_mode(master_mode), .u_bit(u_bit)
);

// File: tb/test_spdif_tx_mux.sv
`timescale 1ns/1ps
module test_spdif_tx_mux;
    localparam int DIV = 1;
    localparam logic [7:0] P_B = 8'b1110_1000;
    localparam logic [7:0] P_M = 8'b1110_0010;
    localparam logic [7:0] P_W = 8'b1110_0100;
    // {rx_sel[2:0], rx_in[7:0], expected tx_out}
    localparam logic [11:0] PT_VEC [12] = '{
        {3'd0, 8'h01, 1'b1}, {3'd0, 8'hFE, 1'b0}, {3'd1, 8'h02, 1'b1},
        {3'd2, 8'h04, 1'b1}, {3'd2, 8'hFB, 1'b0}, {3'd3, 8'h08, 1'b1},
        {3'd4, 8'h10, 1'b1}, {3'd5, 8'hDF, 1'b0}, {3'd6, 8'h40, 1'b1},
        {3'd7, 8'h80, 1'b1}, {3'd7, 8'h7F, 1'b0}, {3'd3, 8'hF7, 1'b0}
    };

    logic        clk = 0, rst_n = 0;
    logic        pcm_wr = 0, pcm_rsel = 0, pcm_vbit = 0;
    logic [23:0] pcm_data = '0;
    logic [39:0] cs_bits = '0;
    logic        cs_auto_chan = 0, ubit_loop = 0, pll_lock = 0, master_mode = 0, ubit_rec = 0;
    logic        enc_sel = 0;
    logic [2:0]  rx_sel = '0;
    logic [7:0]  rx_in = '0;
    logic        tx_out;

    int n_chk = 0, n_fail = 0;
    logic [23:0] e_aud_l = '0, e_aud_r = '0;
    logic        e_v_l = 0, e_v_r = 0;
    bit hq[$];
    bit mon_last = 0;
    int mon_run = 0;

    always #5 clk = ~clk;

    spdif_tx_mux #(.AUD_W(24), .HALF_DIV(DIV), .NRX(8)) i_spdif_tx_mux (
        .clk(clk), .rst_n(rst_n), .pcm_wr(pcm_wr), .pcm_rsel(pcm_rsel),
        .pcm_data(pcm_data), .pcm_vbit(pcm_vbit), .cs_bits(cs_bits),
        .cs_auto_chan(cs_auto_chan), .ubit_loop(ubit_loop), .pll_lock(pll_lock),
        .master_mode(master_mode), .ubit_rec(ubit_rec), .enc_sel(enc_sel),
        .rx_sel(rx_sel), .rx_in(rx_in), .tx_out(tx_out)
    );

    // line monitor: turns run lengths into half-cell levels
    always @(negedge clk) begin
        if (tx_out == mon_last) mon_run++;
        else begin
            for (int k = 0; k < mon_run / DIV && k < 8; k++) hq.push_back(mon_last);
            mon_last = tx_out;
            mon_run  = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_c(int fr, int ch);
        if (fr >= 40) return 1'b0;
        if (!cs_bits[0] && fr >= 20 && fr <= 23)
            return cs_auto_chan ? ((ch == 0 && fr == 20) || (ch == 1 && fr == 21)) : 1'b0;
        return cs_bits[fr];
    endfunction

    task automatic do_sync(output bit lvl);
        bit found = 0;
        while (!found) begin
            while (hq.size() < 70) @(negedge clk);
            if (hq[0] != hq[1] && hq[1] == hq[2] && hq[2] == hq[3] &&
                hq[64] != hq[65] && hq[65] == hq[66] && hq[66] == hq[67]) begin
                lvl = hq.pop_front();
                found = 1;
            end else void'(hq.pop_front());
        end
    endtask

    task automatic read_sf(output bit [7:0] pat, output bit [31:0] bits, output bit ok, inout bit lvl);
        bit s [64];
        bit prevh;
        for (int j = 0; j < 64; j++) begin
            while (hq.size() == 0) @(negedge clk);
            s[j] = hq.pop_front();
        end
        for (int j = 0; j < 8; j++) pat[7-j] = s[j] ^ lvl;
        bits = '0;
        ok = 1;
        prevh = s[7];
        for (int k = 4; k < 32; k++) begin
            if (s[2*k] == prevh) ok = 0;
            bits[k] = s[2*k] ^ s[2*k+1];
            prevh = s[2*k+1];
        end
        lvl = s[63];
    endtask

    task automatic check_block(input bit first_b);
        bit lvl, ok;
        bit [7:0] pat, ep;
        bit [31:0] bits;
        int guard = 0;
        do_sync(lvl);
        read_sf(pat, bits, ok, lvl);
        if (first_b) begin
            chk(pat == P_B, "R1 first preamble", 32'(pat), 32'(P_B));
            chk(bits[28:4] == '0, "R1 first sample", bits, 0);
        end
        chk(ok, "R12 encoder stream decodes", 32'(ok), 1);
        while (pat != P_B && guard < 400) begin
            read_sf(pat, bits, ok, lvl);
            guard++;
        end
        for (int n = 0; n < 384; n++) begin
            int fr = n / 2;
            int ch = n % 2;
            string rq;
            if (n > 0) read_sf(pat, bits, ok, lvl);
            ep = ch ? P_W : ((fr == 0) ? P_B : P_M);
            chk(pat == ep, "R2 preamble", 32'(pat), 32'(ep));
            chk(ok, "R3 cell edges", 32'(ok), 1);
            chk(^bits[31:4] == 1'b0, "R4 parity", bits, 0);
            chk(bits[28:4] == (ch ? {e_v_r, e_aud_r} : {e_v_l, e_aud_l}), "R4 audio/V",
                32'(bits[28:4]), 32'(ch ? {e_v_r, e_aud_r} : {e_v_l, e_aud_l}));
            if (fr >= 40 || fr < 20 || fr > 23) rq = "R5 status";
            else if (cs_bits[0]) rq = "R8 status";
            else rq = cs_auto_chan ? "R6 status" : "R7 status";
            chk(bits[30] == exp_c(fr, ch), rq, {fr[23:0], 7'd0, bits[30]}, {fr[23:0], 7'd0, exp_c(fr, ch)});
            chk(bits[29] == (ubit_loop && pll_lock && master_mode && ubit_rec),
                ubit_loop ? "R10 user" : "R9 user", 32'(bits[29]),
                32'(ubit_loop && pll_lock && master_mode && ubit_rec));
        end
    endtask

    task automatic wr(input bit ch, input logic [23:0] d, input bit v);
        @(negedge clk);
        pcm_wr = 1; pcm_rsel = ch; pcm_data = d; pcm_vbit = v;
        @(negedge clk);
        pcm_wr = 0;
        if (ch) begin e_aud_r = d; e_v_r = v; end
        else    begin e_aud_l = d; e_v_l = v; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state with a high pass-through input selected
        rx_in = 8'hFF;
        repeat (3) begin
            @(negedge clk);
            chk(tx_out == 1'b0, "R1 reset output", 32'(tx_out), 0);
        end
        cs_bits = 40'h5A_3DB6_C29E;   // bit0=0 consumer, bits 23..20 = 1011
        cs_auto_chan = 1;
        enc_sel = 1;
        hq.delete();
        @(negedge clk);
        rst_n = 1;
        check_block(1);               // R1, R2..R6, R9, R12

        // R11: pass-through table
        enc_sel = 0;
        foreach (PT_VEC[i]) begin
            @(negedge clk);
            rx_sel = PT_VEC[i][11:9];
            rx_in  = PT_VEC[i][8:1];
            @(negedge clk);
            chk(tx_out == PT_VEC[i][0], "R11 pass-through", 32'(tx_out), 32'(PT_VEC[i][0]));
        end

        // R7 consumer with auto fill off, R10 user loop active
        wr(0, 24'h8F1234, 0);
        wr(1, 24'h00F0F1, 1);
        cs_auto_chan = 0;
        ubit_loop = 1; pll_lock = 1; master_mode = 1; ubit_rec = 1;
        enc_sel = 1;
        repeat (200) @(negedge clk);
        hq.delete();
        check_block(0);

        // R8 professional mode, R10 loop requested but not locked
        wr(0, 24'h3C5A01, 1);
        wr(1, 24'hFFFFFE, 0);
        cs_bits = 40'h5A_3DB6_C29F;
        cs_auto_chan = 1;
        pll_lock = 0;
        repeat (200) @(negedge clk);
        hq.delete();
        check_block(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule